// File: doc/BRIEF.md
# Prescaled Scanline Interrupt Counter

This block is an 8-bit up-counting interrupt timer. A reload latch supplies the counter's start value. When the counter passes 0xFF it wraps back to the latch value and raises a level interrupt request. That request stays high until software clears it.

The counter can be clocked in two ways:
- **Cycle mode:** the counter advances on every tick.
- **Scanline mode:** a fractional prescaler slows the counter to about one step per video line. The prescaler takes a fixed step off a signed accumulator on each tick. When the accumulator reaches zero or below, the period is added back and the counter advances once.

A tick-enable input stands in for the processor clock. Software uses a small register-write port to:
- load the latch, as a full byte or one nibble at a time;
- write the control fields;
- acknowledge the interrupt.

All internal state can be read on output ports.

Top module: `scan_irq_timer`

## Requirements
- R1: A write with select 0 loads the whole latch from the data byte. Select 1 replaces latch bits 3:0 with data bits 3:0. Select 2 replaces latch bits 7:4 with data bits 3:0.
- R2: A control write (select 3) stores data bit 2 as cycle mode, bit 1 as enable and bit 0 as enable-after-acknowledge. The stored values can be read on `cycleModeOut`, `enabledOut` and `ackEnableOut`.
- R3: A control write clears the pending interrupt and sets the prescaler to its initial value (default 341). When the enable bit is set, the counter is loaded from the latch. When it is clear, the counter keeps its value and the timer is disabled.
- R4: An acknowledge write (select 4) clears the pending interrupt and copies the stored enable-after-acknowledge bit into the enable state.
- R5: While the timer is disabled, ticks change neither the counter nor the prescaler.
- R6: In cycle mode, each enabled tick clocks the counter once. With the latch at L, the interrupt rises on tick 256-L after the control write.
- R7: In scanline mode, each enabled tick subtracts the step (default 3) from the prescaler. If the result is zero or less, the initial value is added back and the counter is clocked. With the latch at 0xFF, the interrupt is low after 113 ticks and high after 114 ticks.
- R8: When the counter is clocked at 0xFF, it reloads from the latch and sets the pending flag. When clocked at any other value, it increments by one.
- R9: `irqOut` equals the pending flag. Only a control write or an acknowledge write clears it. Further overflows leave it high.
- R10: In a cycle where `wrEn` is high, the write takes effect and a tick in the same cycle is ignored.
- R11: A synchronous active-high reset clears the latch, counter, enable, mode, enable-after-acknowledge bit, pending flag and prescaler to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One timer tick per clock cycle while high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Write target: 0 latch, 1 latch low nibble, 2 latch high nibble, 3 control, 4 acknowledge |
| wrData | input | 8 | Write data |
| irqOut | output | 1 | Level interrupt request |
| latchOut | output | 8 | Reload latch value |
| countOut | output | 8 | Counter value |
| enabledOut | output | 1 | Timer enable state |
| cycleModeOut | output | 1 | High in cycle mode, low in scanline mode |
| ackEnableOut | output | 1 | Stored enable-after-acknowledge bit |
| prescaleOut | output | 11 | Signed prescaler accumulator |

## Verification
If the prescaler accumulator drifts, the counter step moves away from tick 114, 228 and so on. This shows on `prescaleOut` at the next tick and on `countOut` by the next line boundary. If the overflow reload or the increment is wrong, the interrupt rises on a tick other than 256-L in cycle mode. A sweep over every latch value checks the edge one tick before and at the expected tick. A wrong enable or priority decision shows within one cycle as a counter that moves when it should hold.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  // Register-write target selected by wrSel.
  typedef enum logic [2:0] {
    SEL_LATCH = 3'd0,
    SEL_LO    = 3'd1,
    SEL_HI    = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_ACK   = 3'd4
  } regSel_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic latchAll;
    logic latchLo;
    logic latchHi;
    logic reload;
    logic clearPend;
    logic stepCount;
  } strobe_t;

endpackage

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl
  import scan_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_INIT = 341,
  parameter int PRE_STEP = 3,
  parameter int PRE_W    = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tickEn,
  input  logic                     wrEn,
  input  logic [2:0]               wrSel,
  input  logic [DATA_W-1:0]        wrData,
  output strobe_t                  strb,
  output logic                     enabled,
  output logic                     cycleMode,
  output logic                     ackEnable,
  output logic signed [PRE_W-1:0]  prescale
);

  localparam logic signed [PRE_W-1:0] INIT_S = PRE_W'(PRE_INIT);
  localparam logic signed [PRE_W-1:0] STEP_S = PRE_W'(PRE_STEP);

  logic signed [PRE_W-1:0] preNext;
  logic tickLive;
  logic ctrlWr;
  logic ackWr;

  assign ctrlWr   = wrEn && (wrSel == SEL_CTRL);
  assign ackWr    = wrEn && (wrSel == SEL_ACK);
  // A write cycle takes priority over a tick in the same cycle.
  assign tickLive = tickEn && enabled && !wrEn;
  assign preNext  = prescale - STEP_S;

  always_comb begin
    strb           = '0;
    strb.latchAll  = wrEn && (wrSel == SEL_LATCH);
    strb.latchLo   = wrEn && (wrSel == SEL_LO);
    strb.latchHi   = wrEn && (wrSel == SEL_HI);
    strb.reload    = ctrlWr && wrData[1];
    strb.clearPend = ctrlWr || ackWr;
    strb.stepCount = tickLive && (cycleMode || (preNext <= 0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled   <= 1'b0;
      cycleMode <= 1'b0;
      ackEnable <= 1'b0;
      prescale  <= '0;
    end else if (ctrlWr) begin
      cycleMode <= wrData[2];
      enabled   <= wrData[1];
      ackEnable <= wrData[0];
      prescale  <= INIT_S;
    end else if (ackWr) begin
      enabled <= ackEnable;
    end else if (tickLive && !cycleMode) begin
      prescale <= (preNext <= 0) ? preNext + INIT_S : preNext;
    end
  end

  AST_PRE_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (prescale >= 0) && (prescale <= INIT_S)) else $error("prescaler out of range"); // R7

  AST_CTRL_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    ctrlWr |=> (prescale == INIT_S)) else $error("prescaler not preloaded"); // R3

  AST_OFF_HOLDS_PRE: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !wrEn) |=> $stable(prescale)) else $error("prescaler moved while off"); // R5

endmodule

// File: rtl/scan_irq_datapath.sv
module scan_irq_datapath
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wrData,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] latch,
  output logic [CNT_W-1:0] count,
  output logic             pending
);

  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
    end else if (strb.latchAll) begin
      latch <= wrData;
    end else if (strb.latchLo) begin
      latch[HALF-1:0] <= wrData[HALF-1:0];
    end else if (strb.latchHi) begin
      latch[CNT_W-1:HALF] <= wrData[HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      pending <= 1'b0;
    end else begin
      if (strb.clearPend) pending <= 1'b0;
      if (strb.reload) begin
        count <= latch;
      end else if (strb.stepCount) begin
        if (count == '1) begin
          count   <= latch;
          pending <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strb.reload || strb.stepCount) |=> $stable(count)) else $error("counter moved"); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (strb.stepCount && !strb.reload && count == '1) |=> (count == $past(latch)) && pending)
    else $error("wrap reload wrong"); // R8

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pending && !strb.clearPend) |=> pending) else $error("pending dropped"); // R9

endmodule

// File: rtl/scan_irq_timer.sv
module scan_irq_timer
  import scan_irq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PRE_INIT = 341,
  parameter int PRE_STEP = 3,
  parameter int PRE_W    = $clog2(PRE_INIT + 1) + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tickEn,
  input  logic                    wrEn,
  input  logic [2:0]              wrSel,
  input  logic [CNT_W-1:0]        wrData,
  output logic                    irqOut,
  output logic [CNT_W-1:0]        latchOut,
  output logic [CNT_W-1:0]        countOut,
  output logic                    enabledOut,
  output logic                    cycleModeOut,
  output logic                    ackEnableOut,
  output logic signed [PRE_W-1:0] prescaleOut
);

  strobe_t strb;

  scan_irq_ctrl #(
    .DATA_W(CNT_W), .PRE_INIT(PRE_INIT), .PRE_STEP(PRE_STEP), .PRE_W(PRE_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .strb(strb), .enabled(enabledOut),
    .cycleMode(cycleModeOut), .ackEnable(ackEnableOut), .prescale(prescaleOut)
  );

  scan_irq_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rst(rst), .wrData(wrData), .strb(strb),
    .latch(latchOut), .count(countOut), .pending(irqOut)
  );

  AST_ACK_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == SEL_ACK) |=> (enabledOut == $past(ackEnableOut)) && !irqOut)
    else $error("acknowledge effect wrong"); // R4

endmodule

// File: tb/sim_scan_irq_timer.sv
`timescale 1ns/1ps
module sim_scan_irq_timer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic irqOut;
  logic [7:0] latchOut;
  logic [7:0] countOut;
  logic enabledOut;
  logic cycleModeOut;
  logic ackEnableOut;
  logic signed [10:0] prescaleOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_irq_timer u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .irqOut(irqOut), .latchOut(latchOut), .countOut(countOut),
    .enabledOut(enabledOut), .cycleModeOut(cycleModeOut),
    .ackEnableOut(ackEnableOut), .prescaleOut(prescaleOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doTick(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    #1_900_000;
    nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int pre;
    int cnt;
    bit irqExp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(latchOut == 0 && countOut == 0 && !irqOut && !enabledOut && !cycleModeOut
          && !ackEnableOut && prescaleOut == 0, "R11", {latchOut, countOut}, 0);

    // R1 full and nibble latch writes
    doWrite(3'd0, 8'hA5);
    check(latchOut == 8'hA5, "R1 full", latchOut, 8'hA5);
    doWrite(3'd1, 8'hFE);
    check(latchOut == 8'hAE, "R1 low", latchOut, 8'hAE);
    doWrite(3'd2, 8'h3F);
    check(latchOut == 8'hFE, "R1 high", latchOut, 8'hFE);

    // R5 disabled: ticks do nothing; control write with enable clear keeps counter
    doWrite(3'd3, 8'h04);
    check(cycleModeOut && !enabledOut && !ackEnableOut, "R2 fields", {cycleModeOut, enabledOut, ackEnableOut}, 4);
    check(countOut == 0 && prescaleOut == 341, "R3 no load", countOut, 0);
    doTick(20);
    check(countOut == 0 && prescaleOut == 341, "R5", countOut, 0);

    // R6 cycle mode sweep over every latch value
    for (int l = 0; l < 256; l++) begin
      doWrite(3'd0, 8'(l));
      doWrite(3'd3, 8'h06);
      check(countOut == 8'(l) && !irqOut, "R3 load", countOut, l);
      doTick(255 - l);
      check(!irqOut && countOut == 8'hFF, "R6 before", {irqOut, countOut}, 8'hFF);
      doTick(1);
      check(irqOut && countOut == 8'(l), "R6 at", {irqOut, countOut}, 256 + l);
    end

    // R9 further overflows keep the request high (latch 0xFE, two more wraps)
    doWrite(3'd0, 8'hFE);
    doWrite(3'd3, 8'h06);
    doTick(2);
    check(irqOut, "R9 first", irqOut, 1);
    doTick(3);
    check(irqOut && countOut == 8'hFF, "R9 sticky", {irqOut, countOut}, 511);
    doTick(1);
    check(irqOut && countOut == 8'hFE, "R8 wrap", {irqOut, countOut}, 510);

    // R4 acknowledge with stored bit 0 disables, with bit 1 keeps enabled
    doWrite(3'd4, 8'h00);
    check(!irqOut && !enabledOut, "R4 off", {irqOut, enabledOut}, 0);
    doTick(5);
    check(countOut == 8'hFE, "R5 after ack", countOut, 8'hFE);
    doWrite(3'd3, 8'h07);
    doTick(2);
    check(irqOut, "R6 ackEn run", irqOut, 1);
    doWrite(3'd4, 8'h00);
    check(!irqOut && enabledOut && ackEnableOut, "R4 keep", {irqOut, enabledOut}, 1);

    // R10 write and tick in the same cycle: tick ignored
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; wrSel = 3'd0; wrData = 8'h10;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    check(latchOut == 8'h10 && countOut == 8'hFE, "R10", countOut, 8'hFE);

    // R7 scanline mode, latch 0xFF: 113 ticks low, 114 high
    doWrite(3'd0, 8'hFF);
    doWrite(3'd3, 8'h02);
    check(prescaleOut == 341 && !cycleModeOut, "R3 preload", prescaleOut, 341);
    doTick(113);
    check(!irqOut && prescaleOut == 2, "R7 113", prescaleOut, 2);
    doTick(1);
    check(irqOut && prescaleOut == 340, "R7 114", prescaleOut, 340);

    // R7/R8 scanline tick-by-tick arithmetic with latch 0xFD over 700 ticks
    doWrite(3'd0, 8'hFD);
    doWrite(3'd3, 8'h02);
    pre = 341; cnt = 8'hFD; irqExp = 1'b0;
    for (int k = 0; k < 700; k++) begin
      doTick(1);
      pre = pre - 3;
      if (pre <= 0) begin
        pre = pre + 341;
        if (cnt == 255) begin cnt = 8'hFD; irqExp = 1'b1; end
        else cnt = cnt + 1;
      end
      if (k % 7 == 0 || pre > 338)
        check(prescaleOut == pre && countOut == 8'(cnt) && irqOut == irqExp,
              "R7 sweep", {prescaleOut, countOut}, {pre[10:0], 8'(cnt)});
    end

    // R11 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(latchOut == 0 && countOut == 0 && !irqOut && !enabledOut && prescaleOut == 0,
          "R11 again", {latchOut, countOut}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule